// File: doc/BRIEF.md
# Comma Detect and Word Aligner

This block sits behind a clock and data recovery stage. It takes the recovered serial stream one bit per bit-clock cycle and cuts it into 10-bit words. When mark detection is enabled, it looks for the positive-disparity 8B/10B comma. The comma is the pattern whose first seven received bits are 0,0,1,1,1,1,1, and its last three bits may be anything. Each time the block reaches the end of a word, it examines a 20-bit history window at all ten candidate offsets in parallel. If a comma lies on the current boundary, nothing changes. If a comma lies at another offset, the block presents that comma word and moves the boundary so that the words after it follow on from it.

With detection disabled, the block keeps whatever boundary it has and delivers unframed words. The detect flag then drops. The enable input passes through a short synchronizer, so the flag follows it within a few bit cycles, well inside three word times.

Each new word comes with a one-cycle strobe. A pair of byte clocks is generated from the strobes, and a mode pin selects one of two forms:
- In full-rate mode, the two clocks are complementary and toggle once per word. The first comma of a run always lands on a high phase of the second clock.
- In half-rate mode, the second clock is a single word-rate clock and the first clock is held low.

Top module: `comma_word_aligner`

## Requirements
- R1: During and right after reset, word_out is 0, comma_flag is 0 and word_stb is 0; with rate_half low, bclk_b is 0 and bclk_a is 1.
- R2: A mark is a word with word_out[6:0] == 7'b1111100, so the first two received bits are 0 and the next five are 1; bits 9:7 are ignored. comma_flag is high only while such a word is on word_out and the synchronized enable is high; it is low for every other word.
- R3: word_stb pulses for one cycle with each new word, every 10 bit cycles, and the first pulse comes 10 cycles after reset. While enabled, a mark found at any bit offset is presented with comma_flag high. The word that follows it in the stream is presented next, and strobes then continue every 10 cycles.
- R4: A mark that lies on the current boundary causes no change: strobes keep their 10-cycle spacing.
- R5: While the synchronized enable is low, the boundary never moves and strobes stay 10 cycles apart. comma_flag is 0 one cycle after the synchronized enable is low.
- R6: After cdet_en changes, comma_flag responds within 3 word strobes.
- R7: In a run of back-to-back marks, strobes stay 10 cycles apart and comma_flag is high for every mark word. In full-rate mode, bclk_b changes level between consecutive mark words.
- R8: With rate_half low, bclk_a is the inverse of bclk_b. bclk_b changes only in the cycle after a strobe, and toggles once per word.
- R9: With rate_half low, in the cycle after the first mark word of a run is strobed, bclk_b is high.
- R10: With rate_half high, bclk_a is 0, and bclk_b is high for the 5 cycles that begin in the cycle after a strobe, then low until the next strobe.
- R11: word_out[0] holds the earliest received bit of the word and word_out[9] the latest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_bit | input | 1 | Recovered serial data, one bit per cycle |
| cdet_en | input | 1 | Enable for mark detection and alignment |
| rate_half | input | 1 | Byte clock mode: 0 complementary half-word-rate pair, 1 single word-rate clock |
| word_out | output | 10 | Aligned word, bit 0 received first |
| comma_flag | output | 1 | High while a mark word is on word_out and detection is enabled |
| word_stb | output | 1 | One-cycle pulse when word_out takes a new word |
| bclk_a | output | 1 | First byte clock (inverse of bclk_b in full-rate mode, 0 in half-rate mode) |
| bclk_b | output | 1 | Second byte clock |

## Verification
An alternating 1/0 filler stream can never contain a mark, so any flag it raises is a false detection. A single mark shifted by three bits shows that the boundary moves to the mark and that the word after it arrives intact. Marks sent on the current boundary, alone and in runs, separate a needless realignment from a correct hold, and they also show the clock-phase forcing and toggling.

A shifted mark sent while detection is disabled must leave the cadence alone. A continuous stream of misaligned marks, sent while the enable is toggled, measures the flag's lag in both directions. A half-rate pass checks the single word-rate clock shape.

// File: rtl/cdr_align_pkg.sv
package cdr_align_pkg;
   localparam int unsigned DEF_WORD_W   = 10;
   localparam int unsigned DEF_MARK_LEN = 7;
   localparam logic [6:0]  DEF_MARK     = 7'b1111100;
   localparam int unsigned DEF_SYNC     = 2;

   typedef enum logic {
      RATE_FULL = 1'b0,
      RATE_HALF = 1'b1
   } rate_e;
endpackage

// File: rtl/aln_window.sv
module aln_window #(
   parameter int unsigned            WORD_W   = 10,
   parameter int unsigned            MARK_LEN = 7,
   parameter logic [MARK_LEN-1:0]    MARK     = 7'b1111100
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ser_bit,
   output logic [2*WORD_W-1:0]   win,
   output logic [WORD_W-1:0]     hit
);
   localparam int unsigned WIN_W = 2 * WORD_W;

   if (MARK_LEN > WORD_W || MARK_LEN < 1) begin : g_bad_len
      $error("aln_window: MARK_LEN must be 1..WORD_W");
   end

   logic [WIN_W-1:0] win_q;

   // newest bit enters at the top, so lower index means earlier bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_q <= '0;
      else        win_q <= {ser_bit, win_q[WIN_W-1:1]};
   end

   assign win = win_q;

   // candidate j is the word that ended j cycles before the current one
   for (genvar j = 0; j < WORD_W; j++) begin : g_cand
      assign hit[j] = (win_q[WORD_W-j +: MARK_LEN] == MARK);
   end
endmodule

// File: rtl/aln_boundary.sv
module aln_boundary #(
   parameter int unsigned            WORD_W   = 10,
   parameter int unsigned            MARK_LEN = 7,
   parameter logic [MARK_LEN-1:0]    MARK     = 7'b1111100,
   parameter int unsigned            SYNC     = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cdet_en,
   input  logic [2*WORD_W-1:0]   win,
   input  logic [WORD_W-1:0]     hit,
   output logic [WORD_W-1:0]     word_out,
   output logic                  comma_flag,
   output logic                  word_stb
);
   localparam int unsigned SEL_W = $clog2(WORD_W);
   localparam logic [SEL_W-1:0] LAST = SEL_W'(WORD_W - 1);

   if (SYNC < 1 || SYNC > 3 * WORD_W - 2) begin : g_bad_sync
      $error("aln_boundary: SYNC must keep the flag lag under three words");
   end
   if (WORD_W < 2) begin : g_bad_w
      $error("aln_boundary: WORD_W must be at least 2");
   end

   logic [SYNC-1:0]  en_pipe;
   logic             en_s;
   logic [SEL_W-1:0] cnt;
   logic [SEL_W-1:0] sel;
   logic             found;
   logic             at_end;
   logic [WORD_W-1:0] cand;

   if (SYNC == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) en_pipe <= '0;
         else        en_pipe <= cdet_en;
      end
   end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) en_pipe <= '0;
         else        en_pipe <= {en_pipe[SYNC-2:0], cdet_en};
      end
   end

   assign en_s   = en_pipe[SYNC-1];
   assign at_end = (cnt == LAST);

   // current boundary wins; otherwise the earliest shifted mark wins
   always_comb begin
      sel   = '0;
      found = 1'b0;
      if (en_s) begin
         if (hit[0]) begin
            found = 1'b1;
         end else begin
            for (int j = 1; j < WORD_W; j++) begin
               if (hit[j]) begin
                  sel   = SEL_W'(j);
                  found = 1'b1;
               end
            end
         end
      end
   end

   assign cand = WORD_W'(win >> (WORD_W - int'(sel)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         word_out   <= '0;
         comma_flag <= 1'b0;
         word_stb   <= 1'b0;
      end else begin
         word_stb <= at_end;
         if (at_end) begin
            cnt        <= sel;
            word_out   <= cand;
            comma_flag <= found;
         end else begin
            cnt        <= cnt + 1'b1;
            comma_flag <= comma_flag & en_s;
         end
      end
   end

   assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);

   assert_word_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !at_end |=> $stable(word_out));

   assert_flag_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |=> !comma_flag);

   assert_flag_marked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      comma_flag |-> (word_out[MARK_LEN-1:0] == MARK));
endmodule

// File: rtl/aln_byteclk.sv
module aln_byteclk
   import cdr_align_pkg::*;
#(
   parameter int unsigned WORD_W = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rate_half,
   input  logic word_stb,
   input  logic comma_flag,
   output logic bclk_a,
   output logic bclk_b
);
   localparam int unsigned HC_W = $clog2(WORD_W);
   localparam logic [HC_W-1:0] HC_MAX = HC_W'(WORD_W - 1);
   localparam logic [HC_W-1:0] HALF   = HC_W'(WORD_W / 2);

   if (WORD_W < 2) begin : g_bad_w
      $error("aln_byteclk: WORD_W must be at least 2");
   end

   logic            ph;
   logic            prev_flag;
   logic [HC_W-1:0] hc;
   rate_e           mode;

   assign mode = rate_e'(rate_half);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= 1'b0;
         prev_flag <= 1'b0;
         hc        <= HC_MAX;
      end else if (word_stb) begin
         ph        <= (comma_flag && !prev_flag) ? 1'b1 : ~ph;
         prev_flag <= comma_flag;
         hc        <= '0;
      end else if (hc != HC_MAX) begin
         hc <= hc + 1'b1;
      end
   end

   always_comb begin
      if (mode == RATE_HALF) begin
         bclk_a = 1'b0;
         bclk_b = (hc < HALF);
      end else begin
         bclk_a = ~ph;
         bclk_b = ph;
      end
   end

   assert_steady_between_words_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!word_stb && !rate_half) ##1 !rate_half |-> $stable(bclk_b));

   assert_first_mark_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (word_stb && comma_flag && !prev_flag && !rate_half) ##1 !rate_half |-> bclk_b);

   assert_run_toggles_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (word_stb && comma_flag && prev_flag && !rate_half) ##1 !rate_half |-> (bclk_b != $past(bclk_b)));

   assert_half_rate_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (word_stb && rate_half) ##1 rate_half |-> (bclk_b && !bclk_a));
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner
   import cdr_align_pkg::*;
#(
   parameter int unsigned               WORD_W   = DEF_WORD_W,
   parameter int unsigned               MARK_LEN = DEF_MARK_LEN,
   parameter logic [MARK_LEN-1:0]       MARK     = DEF_MARK,
   parameter int unsigned               SYNC     = DEF_SYNC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_bit,
   input  logic              cdet_en,
   input  logic              rate_half,
   output logic [WORD_W-1:0] word_out,
   output logic              comma_flag,
   output logic              word_stb,
   output logic              bclk_a,
   output logic              bclk_b
);
   logic [2*WORD_W-1:0] win;
   logic [WORD_W-1:0]   hit;

   aln_window #(.WORD_W(WORD_W), .MARK_LEN(MARK_LEN), .MARK(MARK)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .ser_bit (ser_bit),
      .win     (win),
      .hit     (hit)
   );

   aln_boundary #(.WORD_W(WORD_W), .MARK_LEN(MARK_LEN), .MARK(MARK), .SYNC(SYNC)) u_bnd (
      .clk        (clk),
      .rst_n      (rst_n),
      .cdet_en    (cdet_en),
      .win        (win),
      .hit        (hit),
      .word_out   (word_out),
      .comma_flag (comma_flag),
      .word_stb   (word_stb)
   );

   aln_byteclk #(.WORD_W(WORD_W)) u_clk (
      .clk        (clk),
      .rst_n      (rst_n),
      .rate_half  (rate_half),
      .word_stb   (word_stb),
      .comma_flag (comma_flag),
      .bclk_a     (bclk_a),
      .bclk_b     (bclk_b)
   );
endmodule

// File: tb/sim_comma_word_aligner.sv
module sim_comma_word_aligner;
   localparam int W = 10;
   localparam int HN = 8192;
   localparam logic [9:0] FILL = 10'h155;
   localparam logic [9:0] MK   = 10'b0101111100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_bit = 1'b0;
   logic cdet_en = 1'b0;
   logic rate_half = 1'b0;
   logic [9:0] word_out;
   logic comma_flag, word_stb, bclk_a, bclk_b;

   always #5 clk = ~clk;

   comma_word_aligner u0 (
      .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .cdet_en(cdet_en),
      .rate_half(rate_half), .word_out(word_out), .comma_flag(comma_flag),
      .word_stb(word_stb), .bclk_a(bclk_a), .bclk_b(bclk_b)
   );

   int checks = 0;
   int fails = 0;
   bit done = 0;

   // ---------------- behavioural reference ----------------
   bit bh [0:HN-1];
   bit eh [0:HN-1];
   int me = 0;
   int nxt = W;
   logic [9:0] x_word = '0;
   bit x_flag = 0, x_stb = 0, x_ph = 0, x_pf = 0;
   int x_hc = W - 1;
   bit ens, fnd;
   int sel;
   logic [9:0] cur;

   function automatic logic [9:0] wd(int endE);
      logic [9:0] v;
      for (int i = 0; i < 10; i++) begin
         int idx = endE - 9 + i;
         v[i] = (idx >= 0 && idx < HN) ? bh[idx] : 1'b0;
      end
      return v;
   endfunction

   function automatic bit ismark(logic [9:0] v);
      return v[6:0] == 7'b1111100;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         me = 0; nxt = W; x_word = '0; x_flag = 0; x_stb = 0;
         x_ph = 0; x_pf = 0; x_hc = W - 1;
      end else if (me < HN - 1) begin
         me = me + 1;
         bh[me] = ser_bit;
         eh[me] = cdet_en;
         ens = (me - 2 >= 0) ? eh[me - 2] : 1'b0;
         if (x_stb) begin
            x_ph = (x_flag && !x_pf) ? 1'b1 : !x_ph;
            x_pf = x_flag;
            x_hc = 0;
         end else if (x_hc < W - 1) begin
            x_hc = x_hc + 1;
         end
         if (me == nxt) begin
            cur = wd(me - 1);
            sel = 0; fnd = 0;
            if (ens) begin
               if (ismark(cur)) fnd = 1;
               else begin
                  for (int j = W - 1; j >= 1; j--) begin
                     if (!fnd && ismark(wd(me - 1 - j))) begin
                        sel = j; fnd = 1;
                     end
                  end
               end
            end
            x_word = wd(me - 1 - sel);
            x_flag = fnd;
            x_stb = 1;
            nxt = me + W - sel;
         end else begin
            x_stb = 0;
            x_flag = x_flag & ens;
         end
      end
   end

   // ---------------- per-cycle compare and port log ----------------
   int cyc = 0;
   bit sb [0:HN-1];
   bit fl [0:HN-1];
   bit bb [0:HN-1];
   bit ba [0:HN-1];
   logic [9:0] wl [0:HN-1];
   bit bad;
   bit xa, xb;

   always @(negedge clk) begin
      if (cyc < HN - 1) cyc = cyc + 1;
      sb[cyc] = word_stb; fl[cyc] = comma_flag; bb[cyc] = bclk_b;
      ba[cyc] = bclk_a; wl[cyc] = word_out;
      if (rst_n) begin
         xa = rate_half ? 1'b0 : !x_ph;
         xb = rate_half ? (x_hc < W / 2) : x_ph;
         bad = 0;
         if (word_out !== x_word) begin
            bad = 1; $display("FAIL R11 word act=%h exp=%h", word_out, x_word);
         end
         if (comma_flag !== x_flag) begin
            bad = 1; $display("FAIL R2 flag act=%0d exp=%0d", comma_flag, x_flag);
         end
         if (word_stb !== x_stb) begin
            bad = 1; $display("FAIL R3 strobe act=%0d exp=%0d", word_stb, x_stb);
         end
         if (bclk_a !== xa || bclk_b !== xb) begin
            bad = 1;
            $display("FAIL %s clocks act=%0d%0d exp=%0d%0d", rate_half ? "R10" : "R8",
                     bclk_a, bclk_b, xa, xb);
         end
         checks++;
         if (bad) fails++;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic send_bit(bit b);
      @(negedge clk); #1 ser_bit = b;
   endtask

   task automatic send_word(logic [9:0] v);
      for (int i = 0; i < 10; i++) send_bit(v[i]);
   endtask

   function automatic int next_stb(int from);
      for (int c = from; c <= cyc; c++) if (sb[c]) return c;
      return -1;
   endfunction

   function automatic int next_flag_stb(int from);
      for (int c = from; c <= cyc; c++) if (sb[c] && fl[c]) return c;
      return -1;
   endfunction

   function automatic bit spacing_ok(int from, int to);
      int last = -1;
      for (int c = from; c <= to; c++) begin
         if (sb[c]) begin
            if (last >= 0 && c - last != 10) return 0;
            last = c;
         end
      end
      return 1;
   endfunction

   function automatic int count_flags(int from, int to);
      int n = 0;
      for (int c = from; c <= to; c++) if (sb[c] && fl[c]) n++;
      return n;
   endfunction

   // ---------------- stimulus ----------------
   int mA, mB, mC, mD, mD2, mE, c, c2, c3, n;
   int fq[$];

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(word_out == 10'd0, "R1 word_out", word_out, 0);
      chk(comma_flag == 1'b0 && word_stb == 1'b0, "R1 flag/stb", {comma_flag, word_stb}, 0);
      chk(bclk_b == 1'b0 && bclk_a == 1'b1, "R1 clocks", {bclk_a, bclk_b}, 2);
      #1 rst_n = 1'b1;
      chk(word_out == 10'd0 && word_stb == 1'b0, "R1 after release", word_out, 0);

      // A: mark shifted by three bits
      @(negedge clk); #1 cdet_en = 1'b1;
      repeat (4) send_word(FILL);
      mA = cyc;
      send_bit(1); send_bit(0); send_bit(1);
      send_word(MK);
      repeat (4) send_word(FILL);
      c = next_flag_stb(mA);
      chk(c > 0, "R3 shifted mark flagged", c, 1);
      chk(wl[c] == MK, "R11 mark word bit order", wl[c], MK);
      c2 = next_stb(c + 1);
      chk(wl[c2] == FILL, "R3 word after mark", wl[c2], FILL);
      c3 = next_stb(c2 + 1);
      chk(c3 - c2 == 10, "R3 spacing after realign", c3 - c2, 10);
      chk(count_flags(mA, cyc) == 1, "R2 only mark words flagged", count_flags(mA, cyc), 1);
      chk(ba[c2 + 1] != bb[c2 + 1] && bb[c2 + 1] != bb[c3 + 1], "R8 full-rate toggle",
          {ba[c2 + 1], bb[c2 + 1], bb[c3 + 1]}, 0);

      // B: marks on the boundary, then a run
      mB = cyc;
      send_word(MK); send_word(FILL); send_word(MK); send_word(FILL);
      repeat (4) send_word(MK);
      repeat (2) send_word(FILL);
      chk(spacing_ok(mB, cyc), "R4 cadence kept", 0, 1);
      fq.delete();
      for (int k = mB; k <= cyc; k++) if (sb[k] && fl[k]) fq.push_back(k);
      chk(fq.size() == 6, "R7 flag per mark word", fq.size(), 6);
      if (fq.size() == 6) begin
         chk(bb[fq[0] + 1] == 1'b1, "R9 single mark high", bb[fq[0] + 1], 1);
         chk(bb[fq[2] + 1] == 1'b1, "R9 run start high", bb[fq[2] + 1], 1);
         for (int k = 2; k < 5; k++) begin
            chk(fq[k + 1] - fq[k] == 10, "R7 run spacing", fq[k + 1] - fq[k], 10);
            chk(bb[fq[k] + 1] != bb[fq[k + 1] + 1], "R7 run toggle", bb[fq[k + 1] + 1], !bb[fq[k] + 1]);
         end
      end

      // C: disabled, shifted mark ignored
      @(negedge clk); #1 cdet_en = 1'b0;
      repeat (3) send_word(FILL);
      mC = cyc;
      send_bit(1); send_bit(0); send_bit(1); send_bit(0);
      send_word(MK);
      repeat (3) send_word(FILL);
      chk(count_flags(mC, cyc) == 0, "R5 no flag when disabled", count_flags(mC, cyc), 0);
      chk(spacing_ok(mC, cyc), "R5 no realign when disabled", 0, 1);

      // D: enable toggles over a misaligned mark stream
      @(negedge clk); #1 cdet_en = 1'b1;
      mD = cyc;
      repeat (6) send_word(MK);
      c = next_flag_stb(mD);
      n = 0;
      for (int k = mD + 1; k <= c; k++) if (sb[k]) n++;
      chk(c > 0 && n <= 3, "R6 flag rise lag", n, 3);
      @(negedge clk); #1 cdet_en = 1'b0;
      mD2 = cyc;
      repeat (5) send_word(MK);
      c = -1;
      for (int k = mD2; k <= cyc; k++) if (c < 0 && !fl[k]) c = k;
      n = 0;
      for (int k = mD2 + 1; k <= c; k++) if (sb[k]) n++;
      chk(c > 0 && n <= 3, "R6 flag fall lag", n, 3);

      // E: half-rate clock
      @(negedge clk); #1 rate_half = 1'b1; cdet_en = 1'b1;
      repeat (2) send_word(FILL);
      mE = cyc;
      repeat (4) send_word(FILL);
      c = next_stb(mE);
      c2 = next_stb(c + 1);
      chk(c2 - c == 10, "R10 word spacing", c2 - c, 10);
      chk(bb[c + 1] && !ba[c + 1] && bb[c + 5], "R10 high phase", {ba[c + 1], bb[c + 1], bb[c + 5]}, 3);
      chk(!bb[c + 6] && !ba[c + 6], "R10 low phase", {ba[c + 6], bb[c + 6]}, 0);

      repeat (5) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R1 watchdog expired act=%0d exp=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule